// File: doc/BRIEF.md
# Modulo-2345 Up/Down Counter with Base-8/Base-14 Display

This block keeps a count between 0 and 2344 and moves it one step up or down each time an internal divider produces a tick while counting is enabled. The count wraps at both ends of its range. Software-free front-panel controls drive it: a synchronous clear, and a parallel load that takes a 15-bit binary value from switches. The load refuses any value above 2344 and raises a sticky warning flag instead.

The count is shown on four active-low seven-segment digits. A select input chooses whether those digits show it in base 8 or in base 14, with leading zeros kept. The low bits of the binary count also drive a row of LEDs. The binary count itself is brought out as a port for the surrounding logic. The tick period is a parameter, so a short period can be used in simulation.

Top module: `ctr2345_top`

## Requirements
- R1: After reset, and at all times, the count lies in 0..2344. The `count` port carries it in binary. Reset (active-low, asynchronous) gives count 0 and warning 0.
- R2: On a tick with `enable` high, `count_up` high, and neither clear nor load, the count rises by one in the next cycle. From 2344 it wraps to 0.
- R3: On a tick with `enable` high, `count_up` low, and neither clear nor load, the count falls by one. From 0 it wraps to 2344.
- R4: With `enable` low, or in a cycle without a tick, and with no clear or load, the count keeps its value.
- R5: `clear` acts in any cycle, without waiting for a tick. It sets the count to 0 and drops the warning in the next cycle, and it overrides load and counting.
- R6: `load` without `clear` and with `load_val` <= 2344 acts in any cycle. It places `load_val` in the count and drops the warning in the next cycle. It overrides counting.
- R7: `load` without `clear` and with `load_val` > 2344 leaves the count unchanged and sets `warn`. `warn` stays set until an accepted load or a clear.
- R8: A tick occurs once every `DIV_PERIOD` clock cycles. The first tick falls in the `DIV_PERIOD`-th cycle after reset is released, so the count changes at most once per `DIV_PERIOD` cycles.
- R9: With `radix_sel` = 0, digit k (k = 0 least significant) shows (count / 8^k) mod 8 on `seg_n[7k+6:7k]`, leading zeros included. Bit 0 is segment a and bit 6 is segment g, and a lit segment is 0. The active-high patterns for 0..9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F.
- R10: With `radix_sel` = 1, digit k shows (count / 14^k) mod 14. Values 10..13 use the active-high patterns 77 (A), 7C (b), 39 (C) and 5E (d).
- R11: `leds` equals the low `LED_W` bits of the count at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counting allowed when high |
| count_up | input | 1 | 1 = count up, 0 = count down |
| clear | input | 1 | Synchronous clear to zero |
| load | input | 1 | Parallel load request |
| load_val | input | 15 | Binary value to load |
| radix_sel | input | 1 | Display base: 0 = base 8, 1 = base 14 |
| count | output | 12 | Current binary count |
| warn | output | 1 | Sticky refused-load flag |
| leds | output | LED_W (8) | Low bits of the count |
| seg_n | output | 28 | Four active-low digit patterns, digit 0 in bits 6:0 |

## Verification
Directed runs load 2344 and count up, and load 0 and count down, so that wrap and ordinary stepping are told apart at both edges. Loads of 2345 and 32767 separate refusal from acceptance, and a following clear and a good load show whether the warning is sticky and whether it is released correctly. A hold with `enable` low and a measured tick rate tell the divider apart from the enable gating. A long constrained-random phase mixes overlapping clear, load, direction and radix changes. Every output is compared each cycle against a bench model, which exposes priority errors and base-conversion errors in either radix.

// File: rtl/ctr2345_pkg.sv
package ctr2345_pkg;
  localparam int DIG_W = 4;
  localparam int SEG_W = 7;

  // One step of a wrapping counter over 0..top
  function automatic logic [15:0] wrap_step(input logic [15:0] cur,
                                            input logic up,
                                            input logic [15:0] top);
    if (up) return (cur == top) ? 16'd0 : cur + 16'd1;
    else    return (cur == 16'd0) ? top : cur - 16'd1;
  endfunction

  // Active-high gfedcba glyph, bit 0 = segment a; 14 and 15 are blank
  function automatic logic [SEG_W-1:0] glyph(input logic [DIG_W-1:0] d);
    case (d)
      4'd0:  return 7'h3F;
      4'd1:  return 7'h06;
      4'd2:  return 7'h5B;
      4'd3:  return 7'h4F;
      4'd4:  return 7'h66;
      4'd5:  return 7'h6D;
      4'd6:  return 7'h7D;
      4'd7:  return 7'h07;
      4'd8:  return 7'h7F;
      4'd9:  return 7'h6F;
      4'd10: return 7'h77;
      4'd11: return 7'h7C;
      4'd12: return 7'h39;
      4'd13: return 7'h5E;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/ctr2345_tick_div.sv
module ctr2345_tick_div #(
  parameter int DIV_PERIOD = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV_W = (DIV_PERIOD > 1) ? $clog2(DIV_PERIOD) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_PERIOD - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  generate
    if (DIV_PERIOD > 1) begin : g_gap_chk
      assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ctr2345_core.sv
module ctr2345_core
  import ctr2345_pkg::*;
#(
  parameter int MODULUS = 2345,
  parameter int LOAD_W  = 15,
  parameter int CNT_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              count_up,
  input  logic              clear,
  input  logic              load,
  input  logic [LOAD_W-1:0] load_val,
  output logic [CNT_W-1:0]  count,
  output logic              warn
);
  localparam logic [CNT_W-1:0]  TOP_C = CNT_W'(MODULUS - 1);
  localparam logic [LOAD_W-1:0] TOP_L = LOAD_W'(MODULUS - 1);

  logic             load_ok;
  logic             step;
  logic [CNT_W-1:0] next_val;

  assign load_ok  = (load_val <= TOP_L);
  assign step     = tick & enable;
  assign next_val = CNT_W'(wrap_step(16'(count), count_up, 16'(TOP_C)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      warn  <= 1'b0;
    end else if (clear) begin
      count <= '0;
      warn  <= 1'b0;
    end else if (load) begin
      if (load_ok) begin
        count <= CNT_W'(load_val);
        warn  <= 1'b0;
      end else begin
        warn  <= 1'b1;
      end
    end else if (step) begin
      count <= next_val;
    end
  end

  assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP_C);
  assert_wrap_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !load && count_up && count == TOP_C) |=> count == '0);
  assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !load && !count_up && count == '0) |=> count == TOP_C);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && !step) |=> $stable(count));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && !warn));
  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && load_ok) |=> (count == CNT_W'($past(load_val)) && !warn));
  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && !load_ok) |=> ($stable(count) && warn));
endmodule

// File: rtl/ctr2345_digits.sv
module ctr2345_digits
  import ctr2345_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DIGITS = 4
) (
  input  logic                        radix_sel,
  input  logic [CNT_W-1:0]            value,
  output logic [DIGITS-1:0][DIG_W-1:0] digit
);
  generate
    for (genvar k = 0; k < DIGITS; k++) begin : g_dig
      localparam int W8  = 8 ** k;
      localparam int W14 = 14 ** k;
      logic [DIG_W-1:0] d8, d14;
      assign d8  = DIG_W'((int'(value) / W8) % 8);
      assign d14 = DIG_W'((int'(value) / W14) % 14);
      assign digit[k] = radix_sel ? d14 : d8;
    end
  endgenerate
endmodule

// File: rtl/ctr2345_seg.sv
module ctr2345_seg
  import ctr2345_pkg::*;
(
  input  logic [DIG_W-1:0] digit,
  output logic [SEG_W-1:0] seg_n
);
  assign seg_n = ~glyph(digit);
endmodule

// File: rtl/ctr2345_top.sv
module ctr2345_top
  import ctr2345_pkg::*;
#(
  parameter int MODULUS    = 2345,
  parameter int LOAD_W     = 15,
  parameter int LED_W      = 8,
  parameter int DIGITS     = 4,
  parameter int DIV_PERIOD = 25_000_000,
  parameter int CNT_W      = $clog2(MODULUS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    count_up,
  input  logic                    clear,
  input  logic                    load,
  input  logic [LOAD_W-1:0]       load_val,
  input  logic                    radix_sel,
  output logic [CNT_W-1:0]        count,
  output logic                    warn,
  output logic [LED_W-1:0]        leds,
  output logic [DIGITS*SEG_W-1:0] seg_n
);
  logic                         tick;
  logic [DIGITS-1:0][DIG_W-1:0] digit;

  ctr2345_tick_div #(.DIV_PERIOD(DIV_PERIOD)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ctr2345_core #(.MODULUS(MODULUS), .LOAD_W(LOAD_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .count_up(count_up), .clear(clear), .load(load), .load_val(load_val),
    .count(count), .warn(warn)
  );

  ctr2345_digits #(.CNT_W(CNT_W), .DIGITS(DIGITS)) u_digits (
    .radix_sel(radix_sel), .value(count), .digit(digit)
  );

  generate
    for (genvar k = 0; k < DIGITS; k++) begin : g_seg
      ctr2345_seg u_seg (.digit(digit[k]), .seg_n(seg_n[k*SEG_W +: SEG_W]));

      assert_digit_base8_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !radix_sel |-> digit[k] < DIG_W'(8));
      assert_digit_base14_R10: assert property (@(posedge clk) disable iff (!rst_n)
        radix_sel |-> digit[k] < DIG_W'(14));
    end
  endgenerate

  assign leds = count[LED_W-1:0];
endmodule

// File: tb/ctr2345_top_tb.sv
module ctr2345_top_tb;
  localparam int P    = 4;
  localparam int TOPV = 2344;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, count_up, clear, load, radix_sel;
  logic [14:0] load_val;
  logic [11:0] count;
  logic        warn;
  logic [7:0]  leds;
  logic [27:0] seg_n;

  int errors = 0, checks = 0;
  int m_cnt = 0, m_div = 0;
  bit m_warn = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ctr2345_top #(.DIV_PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count_up(count_up),
    .clear(clear), .load(load), .load_val(load_val), .radix_sel(radix_sel),
    .count(count), .warn(warn), .leds(leds), .seg_n(seg_n)
  );

  function automatic int pattern(int d);
    int hi[14] = '{'h3F,'h06,'h5B,'h4F,'h66,'h6D,'h7D,'h07,'h7F,'h6F,
                   'h77,'h7C,'h39,'h5E};
    return (~hi[d]) & 'h7F;
  endfunction

  function automatic int exp_seg(int v, bit r14);
    int b = r14 ? 14 : 8;
    int acc = 0;
    for (int k = 0; k < 4; k++) begin
      acc |= pattern(v % b) << (7 * k);
      v = v / b;
    end
    return acc;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, int'(count), m_cnt);
    chk("R7 warn", int'(warn), int'(m_warn));
    chk("R11 leds", int'(leds), m_cnt & 'hFF);
    chk(radix_sel ? "R10 seg" : "R9 seg", int'(seg_n), exp_seg(m_cnt, radix_sel));
  endtask

  // Apply inputs at a falling edge, advance one rising edge, update model, check.
  task automatic step(string tag);
    bit t;
    @(posedge clk);
    t = (m_div == P - 1);
    m_div = t ? 0 : m_div + 1;
    if (clear) begin
      m_cnt = 0; m_warn = 0;
    end else if (load) begin
      if (int'(load_val) <= TOPV) begin m_cnt = int'(load_val); m_warn = 0; end
      else m_warn = 1;
    end else if (t && enable) begin
      if (count_up) m_cnt = (m_cnt == TOPV) ? 0 : m_cnt + 1;
      else          m_cnt = (m_cnt == 0) ? TOPV : m_cnt - 1;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    clear = 0; load = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int start;
    void'($urandom(32'd2345));
    rst_n = 0; enable = 0; count_up = 1; clear = 0; load = 0;
    load_val = '0; radix_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check_all("R1 reset count");

    // R6 + R2: load the top, count up across the wrap
    load = 1; load_val = 15'd2344; step("R6 load 2344");
    chk("R9 display 4450", int'(seg_n), exp_seg(2344, 0));
    idle(); enable = 1; count_up = 1; radix_sel = 1;
    for (int i = 0; i < 10; i++) step("R2 up wrap");

    // R3: count down across zero
    load = 1; load_val = 15'd0; step("R6 load 0");
    idle(); count_up = 0; radix_sel = 0;
    for (int i = 0; i < 10; i++) step("R3 down wrap");

    // R7: refused loads, sticky warning, release by clear (R5) and by load
    start = m_cnt;
    load = 1; load_val = 15'd2345; step("R7 refuse 2345");
    chk("R7 count kept", int'(count), start);
    chk("R7 warn set", int'(warn), 1);
    load_val = 15'h7FFF; step("R7 refuse 32767");
    idle(); enable = 0;
    for (int i = 0; i < 5; i++) step("R7 sticky");
    chk("R7 warn sticky", int'(warn), 1);
    clear = 1; load = 1; load_val = 15'd100; step("R5 clear over load");
    chk("R5 clear count", int'(count), 0);
    chk("R5 clear warn", int'(warn), 0);
    idle(); load = 1; load_val = 15'd3000; step("R7 refuse");
    load_val = 15'd1234; step("R6 accept");
    chk("R6 warn released", int'(warn), 0);
    chk("R6 value", int'(count), 1234);

    // R4: enable low holds
    idle(); enable = 0; radix_sel = 1;
    for (int i = 0; i < 12; i++) step("R4 hold");
    chk("R4 held value", int'(count), 1234);

    // R8: tick rate, 40 cycles give 10 steps
    enable = 1; count_up = 1;
    start = int'(count);
    for (int i = 0; i < 40; i++) step("R8 rate");
    chk("R8 steps in 40 cycles", int'(count) - start, 40 / P);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      clear = (r < 2);
      load  = (r >= 2 && r < 8);
      if ($urandom % 2) load_val = 15'($urandom % 2345);
      else              load_val = 15'(2345 + $urandom % (32768 - 2345));
      enable = ($urandom % 10) < 8;
      if ($urandom % 16 == 0) count_up = ~count_up;
      if ($urandom % 8 == 0) radix_sel = ~radix_sel;
      step("R1 random count");
    end
    finish_run();
  end
endmodule